// File: doc/BRIEF.md
# Dual Halfword Multiply-Accumulate Long Unit

This execution unit serves a 32-bit processor pipeline. It takes an instruction word, two source operands and a 64-bit accumulator that arrives as separate low and high words. It splits both operands into signed 16-bit halves and forms two lane products. On request it exchanges the two halves of the second operand first. The two products are then summed or differenced, and the signed result is folded into the 64-bit accumulator.

The unit also pulls the register indices, the condition code and the two small opcode fields out of the instruction word. These outputs let the surrounding pipeline read the register file and later write the result back. Flag evaluation lives outside the unit, and a single condition-pass input stands in for it. The result is registered one cycle after a valid strobe. It comes with a valid pulse and a write-enable that tells whether the instruction actually executed.

Top module: `dhmac_unit`

## Requirements
- R1: Decoded outputs follow the instruction word. The condition is bits 31:28, the first opcode field is bits 22:20, the high-destination index is 19:16, the low-destination index is 15:12, the second-source index is 11:8, the second opcode field is 7:5 and the first-source index is 3:0. Source, condition and opcode outputs are combinational. The two destination indices are registered with the result.
- R2: When instruction bit 5 is 1, the upper and lower 16-bit halves of the second operand are exchanged before multiplication. When it is 0, they are used in place.
- R3: Lane product A is the signed 16x16 product of the low halves. Lane product B is the signed product of the high halves. Every half is read as two's complement.
- R4: Instruction bit 6 selects how the products combine: 0 gives A+B and 1 gives A-B. The combination is formed at 33 bits, so two products of (-32768)*(-32768) give +2^31 with no wrap.
- R5: The combined value is sign-extended to 64 bits and added to {high word, low word}. The sum wraps modulo 2^64, with no saturation. Its bits 31:0 go to the low output and bits 63:32 go to the high output.
- R6: Condition code 0xE always executes. Any other code executes only when the condition-pass input is 1. A skipped instruction returns the incoming low and high words unchanged and leaves the write-enable at 0.
- R7: The cycle after a valid strobe, the result-valid output is 1 for one cycle, and the write-enable is 1 exactly when the instruction executed. In a cycle with no strobe, result-valid and write-enable are 0 and the result and destination outputs keep their values.
- R8: While the active-low synchronous reset is 0 at a clock edge, the result words, destination indices, result-valid and write-enable are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| instr | input | 32 | Instruction word |
| src_n | input | DATA_W | First source operand |
| src_m | input | DATA_W | Second source operand (halves may be exchanged) |
| acc_lo_in | input | DATA_W | Current accumulator low word |
| acc_hi_in | input | DATA_W | Current accumulator high word |
| cond_pass | input | 1 | External condition result |
| dec_cond | output | 4 | Condition code |
| dec_op1 | output | 3 | First opcode field |
| dec_op2 | output | 3 | Second opcode field |
| rd_n_idx | output | 4 | First-source register index |
| rd_m_idx | output | 4 | Second-source register index |
| res_valid | output | 1 | Result valid pulse |
| res_wr_en | output | 1 | Write-back enable |
| res_lo | output | DATA_W | Result low word |
| res_hi | output | DATA_W | Result high word |
| wb_lo_idx | output | 4 | Registered low-destination index |
| wb_hi_idx | output | 4 | Registered high-destination index |

## Verification
The bench builds the unit with DATA_W at its default of 32. At that width the 16-bit lane extremes, the 33-bit combination and a carry or borrow across the 32-bit word seam can all be driven directly. Directed cases reach each of these corners: both lanes at -32768, the difference of a most-negative product and a most-positive product, an all-ones accumulator rolling over to zero, and a borrow out of the low word. Random instructions with random condition codes then cover both the executed and the skipped paths.

// File: rtl/dhmac_pkg.sv
// Shared field layout and decoded-field type for the dual halfword MAC unit.
// Assumes a 32-bit instruction word with fixed field positions.
package dhmac_pkg;
    localparam int INSTR_W = 32;
    localparam int IDX_W   = 4;
    localparam int COND_W  = 4;
    localparam int OPF_W   = 3;
    localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

    typedef struct packed {
        logic [COND_W-1:0] cond;
        logic [OPF_W-1:0]  op1;
        logic [IDX_W-1:0]  hi_idx;
        logic [IDX_W-1:0]  lo_idx;
        logic [IDX_W-1:0]  m_idx;
        logic [OPF_W-1:0]  op2;
        logic [IDX_W-1:0]  n_idx;
    } dhmac_fields_t;
endpackage

// File: rtl/dhmac_decode.sv
// Instruction field extraction and execute decision.
// Assumes the external condition evaluation is already folded into cond_pass.
module dhmac_decode
    import dhmac_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               cond_pass,
    output dhmac_fields_t      fields,
    output logic               do_exec,
    output logic               swap_m,
    output logic               subtract
);
    // Slice the fixed field positions out of the word.
    always_comb begin
        fields.cond   = instr[31:28];
        fields.op1    = instr[22:20];
        fields.hi_idx = instr[19:16];
        fields.lo_idx = instr[15:12];
        fields.m_idx  = instr[11:8];
        fields.op2    = instr[7:5];
        fields.n_idx  = instr[3:0];
    end

    // Execute decision and operation modifiers taken from the fields.
    always_comb begin
        do_exec  = (fields.cond == COND_ALWAYS) || cond_pass;
        swap_m   = fields.op2[0];
        subtract = fields.op2[1];
    end
endmodule

// File: rtl/dhmac_lanes.sv
// Two signed halfword multiplier lanes, with optional exchange of the
// second operand's halves. Assumes DATA_W is even.
module dhmac_lanes #(
    parameter int DATA_W = 32
) (
    input  logic                     [DATA_W-1:0] op_n,
    input  logic                     [DATA_W-1:0] op_m,
    input  logic                                  swap_m,
    output logic signed [1:0][DATA_W-1:0]         prod
);
    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = 2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [HALF_W-1:0] h_n;
        logic signed [HALF_W-1:0] h_m;
        logic signed [DATA_W-1:0] ext_n;
        logic signed [DATA_W-1:0] ext_m;

        // Pick this lane's halves; a swap takes the opposite half of op_m.
        always_comb begin
            h_n = op_n[g*HALF_W +: HALF_W];
            h_m = swap_m ? op_m[(LANES-1-g)*HALF_W +: HALF_W]
                         : op_m[g*HALF_W +: HALF_W];
        end

        // Sign-extend both halves and multiply at full product width.
        always_comb begin
            ext_n   = {{HALF_W{h_n[HALF_W-1]}}, h_n};
            ext_m   = {{HALF_W{h_m[HALF_W-1]}}, h_m};
            prod[g] = ext_n * ext_m;
        end
    end
endmodule

// File: rtl/dhmac_accum.sv
// Combines the two lane products (sum or difference) one bit wider than a
// product, then adds the sign-extended value to the split 64-bit accumulator.
module dhmac_accum #(
    parameter int DATA_W = 32
) (
    input  logic signed [DATA_W-1:0] prod_a,
    input  logic signed [DATA_W-1:0] prod_b,
    input  logic                     subtract,
    input  logic        [DATA_W-1:0] acc_lo,
    input  logic        [DATA_W-1:0] acc_hi,
    output logic        [DATA_W-1:0] sum_lo,
    output logic        [DATA_W-1:0] sum_hi
);
    localparam int COMB_W = DATA_W + 1;
    localparam int ACC_W  = 2 * DATA_W;

    logic signed [COMB_W-1:0] a_w;
    logic signed [COMB_W-1:0] b_w;
    logic signed [COMB_W-1:0] comb;
    logic        [ACC_W-1:0]  comb_ext;
    logic        [ACC_W-1:0]  total;

    // Widen the products by one bit and form sum or difference.
    always_comb begin
        a_w  = {prod_a[DATA_W-1], prod_a};
        b_w  = {prod_b[DATA_W-1], prod_b};
        comb = subtract ? (a_w - b_w) : (a_w + b_w);
    end

    // Sign-extend to accumulator width and add, wrapping modulo 2^ACC_W.
    always_comb begin
        comb_ext = {{(ACC_W-COMB_W){comb[COMB_W-1]}}, comb};
        total    = {acc_hi, acc_lo} + comb_ext;
        sum_lo   = total[DATA_W-1:0];
        sum_hi   = total[ACC_W-1:DATA_W];
    end
endmodule

// File: rtl/dhmac_unit.sv
// Dual halfword multiply-accumulate long unit: decode, two signed lane
// products, sum/difference, 64-bit accumulate, one result register stage.
// Assumes the register file supplies the operands in the strobe cycle.
module dhmac_unit
    import dhmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    src_n,
    input  logic [DATA_W-1:0]    src_m,
    input  logic [DATA_W-1:0]    acc_lo_in,
    input  logic [DATA_W-1:0]    acc_hi_in,
    input  logic                 cond_pass,
    output logic [COND_W-1:0]    dec_cond,
    output logic [OPF_W-1:0]     dec_op1,
    output logic [OPF_W-1:0]     dec_op2,
    output logic [IDX_W-1:0]     rd_n_idx,
    output logic [IDX_W-1:0]     rd_m_idx,
    output logic                 res_valid,
    output logic                 res_wr_en,
    output logic [DATA_W-1:0]    res_lo,
    output logic [DATA_W-1:0]    res_hi,
    output logic [IDX_W-1:0]     wb_lo_idx,
    output logic [IDX_W-1:0]     wb_hi_idx
);
    dhmac_fields_t                 fields;
    logic                          do_exec;
    logic                          swap_m;
    logic                          subtract;
    logic signed [1:0][DATA_W-1:0] prod;
    logic [DATA_W-1:0]             sum_lo;
    logic [DATA_W-1:0]             sum_hi;
    logic [DATA_W-1:0]             nxt_lo;
    logic [DATA_W-1:0]             nxt_hi;

    dhmac_decode u_dec (
        .instr     (instr),
        .cond_pass (cond_pass),
        .fields    (fields),
        .do_exec   (do_exec),
        .swap_m    (swap_m),
        .subtract  (subtract)
    );

    dhmac_lanes #(.DATA_W(DATA_W)) u_lanes (
        .op_n   (src_n),
        .op_m   (src_m),
        .swap_m (swap_m),
        .prod   (prod)
    );

    dhmac_accum #(.DATA_W(DATA_W)) u_acc (
        .prod_a   (prod[0]),
        .prod_b   (prod[1]),
        .subtract (subtract),
        .acc_lo   (acc_lo_in),
        .acc_hi   (acc_hi_in),
        .sum_lo   (sum_lo),
        .sum_hi   (sum_hi)
    );

    // Present decoded source, condition and opcode fields to the pipeline.
    always_comb begin
        dec_cond = fields.cond;
        dec_op1  = fields.op1;
        dec_op2  = fields.op2;
        rd_n_idx = fields.n_idx;
        rd_m_idx = fields.m_idx;
    end

    // A skipped instruction passes the incoming accumulator through.
    always_comb begin
        nxt_lo = do_exec ? sum_lo : acc_lo_in;
        nxt_hi = do_exec ? sum_hi : acc_hi_in;
    end

    // Result stage: capture on a strobe, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_wr_en <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
            wb_lo_idx <= '0;
            wb_hi_idx <= '0;
        end else begin
            res_valid <= in_valid;
            res_wr_en <= in_valid && do_exec;
            if (in_valid) begin
                res_lo    <= nxt_lo;
                res_hi    <= nxt_hi;
                wb_lo_idx <= fields.lo_idx;
                wb_hi_idx <= fields.hi_idx;
            end
        end
    end

    // Write-enable never rises without a result-valid pulse.
    p_wr_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_en |-> res_valid);

    // A strobe yields a valid pulse on the next cycle; no strobe yields none.
    p_strobe_to_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    p_no_strobe_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !res_wr_en));

    // Idle cycles leave the result words untouched.
    p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi)));

    // The always-execute code writes regardless of cond_pass.
    p_always_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:28] == 4'hE) |=> res_wr_en);

    // A skipped instruction returns the incoming accumulator unchanged.
    p_skip_passes_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:28] != 4'hE && !cond_pass) |=>
        (!res_wr_en && res_lo == $past(acc_lo_in) && res_hi == $past(acc_hi_in)));

    // Zero lane products leave the accumulator value as it came in.
    p_zero_products_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && do_exec && prod[0] == '0 && prod[1] == '0) |=>
        ({res_hi, res_lo} == $past({acc_hi_in, acc_lo_in})));

    // A reset edge clears every registered output.
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_wr_en && res_lo == '0 && res_hi == '0
                    && wb_lo_idx == '0 && wb_hi_idx == '0));
endmodule

// File: tb/sim_dhmac_unit.sv
`timescale 1ns/1ps
module sim_dhmac_unit;
    localparam int  DATA_W = 32;
    localparam real CLK_NS = 20.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       instr = '0;
    logic [DATA_W-1:0] src_n = '0, src_m = '0, acc_lo_in = '0, acc_hi_in = '0;
    logic              cond_pass = 1'b0;
    logic [3:0]        dec_cond, rd_n_idx, rd_m_idx, wb_lo_idx, wb_hi_idx;
    logic [2:0]        dec_op1, dec_op2;
    logic              res_valid, res_wr_en;
    logic [DATA_W-1:0] res_lo, res_hi;

    int n_chk = 0;
    int n_bad = 0;

    // Behavioural model state
    logic [63:0] e_acc = '0;
    logic [3:0]  e_lo_idx = '0, e_hi_idx = '0;
    logic        e_valid = 1'b0, e_wr = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    dhmac_unit #(.DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_n(src_n), .src_m(src_m), .acc_lo_in(acc_lo_in), .acc_hi_in(acc_hi_in),
        .cond_pass(cond_pass), .dec_cond(dec_cond), .dec_op1(dec_op1), .dec_op2(dec_op2),
        .rd_n_idx(rd_n_idx), .rd_m_idx(rd_m_idx), .res_valid(res_valid),
        .res_wr_en(res_wr_en), .res_lo(res_lo), .res_hi(res_hi),
        .wb_lo_idx(wb_lo_idx), .wb_hi_idx(wb_hi_idx)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] w, input logic [31:0] n,
                                          input logic [31:0] m, input logic [63:0] acc);
        logic [31:0] mm;
        shortint     nl, nh, ml, mh;
        longint      pa, pb, c;
        mm = w[5] ? {m[15:0], m[31:16]} : m;
        nl = n[15:0];  nh = n[31:16];
        ml = mm[15:0]; mh = mm[31:16];
        pa = longint'(nl) * longint'(ml);
        pb = longint'(nh) * longint'(mh);
        c  = w[6] ? (pa - pb) : (pa + pb);
        return acc + c;
    endfunction

    // Compare all registered outputs against the model.
    task automatic compare_regs(input string tag);
        check({tag, " R7 valid"}, {63'd0, res_valid}, {63'd0, e_valid});
        check({tag, " R6 wr_en"}, {63'd0, res_wr_en}, {63'd0, e_wr});
        check({tag, " R5 result"}, {res_hi, res_lo}, e_acc);
        check({tag, " R1 wb idx"}, {56'd0, wb_hi_idx, wb_lo_idx}, {56'd0, e_hi_idx, e_lo_idx});
    endtask

    // One clock step: drive at negedge, check decode, clock, check registers.
    task automatic step(input string tag, input logic v, input logic [31:0] w,
                        input logic [31:0] n, input logic [31:0] m,
                        input logic [63:0] acc, input logic cp);
        logic exe;
        in_valid = v; instr = w; src_n = n; src_m = m;
        acc_lo_in = acc[31:0]; acc_hi_in = acc[63:32]; cond_pass = cp;
        #1;
        check({tag, " R1 decode"},
              {41'd0, dec_cond, dec_op1, dec_op2, rd_n_idx, rd_m_idx},
              {41'd0, w[31:28], w[22:20], w[7:5], w[3:0], w[11:8]});
        exe = (w[31:28] == 4'hE) || cp;
        e_valid = v;
        e_wr = v && exe;
        if (v) begin
            e_acc = exe ? model(w, n, m, acc) : acc;
            e_lo_idx = w[15:12];
            e_hi_idx = w[19:16];
        end
        @(posedge clk);
        @(negedge clk);
        compare_regs(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        e_acc = '0; e_lo_idx = '0; e_hi_idx = '0; e_valid = 1'b0; e_wr = 1'b0;
        compare_regs("R8 reset");
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] mk(input logic [3:0] c, input logic sub, input logic sw,
                                       input logic [3:0] hi, input logic [3:0] lo);
        return {c, 5'b0, 3'b101, hi, lo, 4'h7, 1'b0, sub, sw, 1'b1, 4'h3};
    endfunction

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R4 sum: 3*5 + 2*(-4) = 7 onto 100
        step("R4 add", 1, mk(4'hE,0,0,4'h2,4'h1), {16'd2,16'd3}, {16'hFFFC,16'd5}, 64'd100, 0);
        check("R4 add value", {res_hi,res_lo}, 64'd107);
        // R2 swap: m halves exchanged -> 3*(-4) + 2*5 = -2
        step("R2 swap", 1, mk(4'hE,0,1,4'h4,4'h5), {16'd2,16'd3}, {16'hFFFC,16'd5}, 64'd0, 0);
        check("R2 swap value", {res_hi,res_lo}, 64'hFFFF_FFFF_FFFF_FFFE);
        // R4 difference: 3*5 - 2*(-4) = 23
        step("R4 sub", 1, mk(4'hE,1,0,4'h6,4'h7), {16'd2,16'd3}, {16'hFFFC,16'd5}, 64'd0, 0);
        check("R4 sub value", {res_hi,res_lo}, 64'd23);
        // R3/R4 extreme: both lanes (-32768)^2 -> 2^31 without wrap
        step("R4 extreme", 1, mk(4'hE,0,0,4'h1,4'h0), 32'h8000_8000, 32'h8000_8000, 64'd0, 0);
        check("R4 extreme value", {res_hi,res_lo}, 64'h0000_0000_8000_0000);
        // R3 most-negative minus mixed-sign product
        step("R3 mixed", 1, mk(4'hE,1,0,4'h1,4'h0), 32'h8000_8000, 32'h7FFF_8000, 64'd0, 0);
        check("R3 mixed value", {res_hi,res_lo}, 64'h0000_0000_7FFF_8000);
        // R5 wrap: all-ones accumulator plus 1 -> 0
        step("R5 wrap", 1, mk(4'hE,0,0,4'h9,4'h8), 32'h0000_0001, 32'h0000_0001,
             64'hFFFF_FFFF_FFFF_FFFF, 0);
        check("R5 wrap value", {res_hi,res_lo}, 64'd0);
        // R5 borrow across the word seam: {1,0} - 1
        step("R5 borrow", 1, mk(4'hE,1,0,4'h3,4'h2), 32'h0001_0000, 32'h0001_0000,
             64'h0000_0001_0000_0000, 0);
        check("R5 borrow value", {res_hi,res_lo}, 64'h0000_0000_FFFF_FFFF);
        // R6 condition: skipped, then executed by pass input
        step("R6 skip", 1, mk(4'h0,0,0,4'hA,4'hB), 32'h0003_0003, 32'h0003_0003,
             64'h1234_5678_9ABC_DEF0, 0);
        check("R6 skip value", {res_hi,res_lo}, 64'h1234_5678_9ABC_DEF0);
        step("R6 pass", 1, mk(4'h0,0,0,4'hA,4'hB), 32'h0003_0003, 32'h0003_0003,
             64'h1234_5678_9ABC_DEF0, 1);
        // R7 idle cycles: no pulse, values held
        step("R7 idle", 0, 32'hFFFF_FFFF, 32'h1111_1111, 32'h2222_2222, 64'd5, 1);
        step("R7 idle2", 0, 32'h0, 32'h0, 32'h0, 64'd0, 0);
        // Random mix over all condition codes and opcode bits
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            w = $urandom;
            step("rand", ($urandom % 4) != 0, w, $urandom, $urandom,
                 {$urandom, $urandom}, $urandom % 2);
        end
        // R8 reset in mid-run
        step("pre-reset", 1, mk(4'hE,0,0,4'hF,4'hE), 32'h1234_5678, 32'h9ABC_DEF0, 64'd77, 0);
        do_reset();
        step("post-reset", 1, mk(4'hE,0,1,4'h5,4'h4), 32'h7FFF_7FFF, 32'h7FFF_8000, 64'd1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule